// File: doc/BRIEF.md
# Buck Converter Fault Supervisor

This block watches a synchronous buck controller once per switching period and decides when the converter must stop. It takes a strobe that marks the start of every PWM period, a free-running microsecond tick, and a set of comparator flags from the analog side: peak current limit, feedback under-voltage, feedback over-voltage, high-side switch short, feedback-short-during-start, and a flag that says the soft-start ramp is still below its 1.5 V point. From these it drives an inhibit for the upper gate, a sticky fault latch, and a lower-gate command that bleeds the output down after a fault.

Over-current is handled in two phases. A current-limit hit at the start of a period skips the upper gate for that period and a fixed number of following periods. A watch window of further periods follows, and a second hit inside it latches the fault; a quiet window returns the logic to normal. The slow faults (under-voltage, over-voltage, feedback short) must persist for a set time before they count, and over-current and under-voltage are ignored while soft-start is low. Once latched, the fault stays until enable is dropped or the block is reset, and the lower gate toggles with hysteresis on the output voltage.

Top module: `buck_fault_supervisor`

## Requirements
- R1: When `ilim_det` is high in a clock where `cyc_start` is high and no skip is in progress, `ugate_inhibit` goes high from the next clock and stays high for that period and the next SKIP_CYCLES (default 8) periods, i.e. until the SKIP_CYCLES-th following strobe.
- R2: During the watch window of WIN_CYCLES (default 8) periods that follows the skip, `ilim_det` high in any clock (strobe or not, soft-start not low) sets the fault latch at the next clock.
- R3: If the window passes without a hit, the over-current logic returns to idle and `ugate_inhibit` drops; a hit seen on the very strobe that closes the window starts a new skip instead of a fault.
- R4: `fb_under` held high across UV_US (default 2) `us_tick` pulses sets the fault latch on the clock after the count is reached; going low clears the count.
- R5: `fb_over` held high across OV_CYCLES (default 16) `cyc_start` strobes sets the fault latch; a shorter run followed by a low clears the count without a fault.
- R6: While `ss_low` is high, over-current and under-voltage cannot set the latch (an over-current hit in the window then restarts the skip on a strobe), while over-voltage, high-side short and feedback short still can; a persisted under-voltage latches once `ss_low` falls.
- R7: `hs_short` high for one clock sets the latch at the next clock; `fb_short` held across FBS_US (default 14) ticks sets it too, both regardless of `ss_low`.
- R8: While latched, `lgate_discharge` is high from the first latched clock, goes low the clock after `out_below_lo` is seen high, and goes high again the clock after `out_above_hi` is seen high while low.
- R9: The latch holds while `enable` is high, forces `ugate_inhibit` high, and clears the clock after `enable` is sampled low.
- R10: After reset, or while `enable` is low, all three outputs are low and every persistence count and the over-current episode start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| enable | input | 1 | Converter enable; low clears the latch |
| cyc_start | input | 1 | One-clock strobe at the start of each PWM period |
| us_tick | input | 1 | One-clock pulse every microsecond |
| ilim_det | input | 1 | Peak current above limit |
| fb_under | input | 1 | Feedback below under-voltage threshold |
| fb_over | input | 1 | Feedback above over-voltage threshold |
| hs_short | input | 1 | High-side switch short detected |
| fb_short | input | 1 | Output rising with feedback near ground |
| ss_low | input | 1 | Soft-start ramp still below 1.5 V |
| out_below_lo | input | 1 | Output below the 0.5 V discharge floor |
| out_above_hi | input | 1 | Output above the 0.8 V discharge ceiling |
| ugate_inhibit | output | 1 | Suppress the upper gate |
| fault_latched | output | 1 | Fault latch state |
| lgate_discharge | output | 1 | Force the lower gate on to discharge |

## Verification
Two things can coincide in a single clock: the strobe that closes the over-current window can arrive together with a fresh current-limit hit, and an over-voltage count can finish on the same strobe where a current-limit hit starts or ends a skip. Long runs of periodic current-limit pulses at a pitch that drifts against the window length, and an over-voltage run overlapped with skips, push these collisions through; a behavioural model in the bench decides, for every clock, whether the outcome is a restart, a fault or idle, and any output disagreement is flagged.

// File: rtl/buck_fault_pkg.sv
package buck_fault_pkg;

    // Width of the shared skip/window period counter.
    localparam int OC_CNT_W = 4;

    typedef enum logic [1:0] {
        OC_IDLE   = 2'd0,
        OC_SKIP   = 2'd1,
        OC_WINDOW = 2'd2
    } oc_phase_e;

    typedef struct packed {
        oc_phase_e             phase;
        logic [OC_CNT_W-1:0]   cnt;
    } oc_state_t;

    typedef struct packed {
        logic fault;
        logic lgate;
    } dis_state_t;

endpackage

// File: rtl/oc_skip_guard.sv
module oc_skip_guard
    import buck_fault_pkg::*;
#(
    parameter int SKIP_CYCLES = 8,
    parameter int WIN_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cyc_start,
    input  logic ilim,
    input  logic mask,
    output logic skipping,
    output logic oc_trip
);

    localparam logic [OC_CNT_W-1:0] SKIP_LAST = OC_CNT_W'(SKIP_CYCLES - 1);
    localparam logic [OC_CNT_W-1:0] WIN_LAST  = OC_CNT_W'(WIN_CYCLES - 1);
    localparam oc_state_t ST_IDLE = '{phase: OC_IDLE, cnt: '0};
    localparam oc_state_t ST_SKIP = '{phase: OC_SKIP, cnt: '0};
    localparam oc_state_t ST_WIN  = '{phase: OC_WINDOW, cnt: '0};

    oc_state_t st_d, st_q;
    logic      trip_d;

    always_comb begin
        st_d   = st_q;
        trip_d = 1'b0;
        if (clr) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q.phase)
                OC_IDLE: begin
                    if (cyc_start && ilim) st_d = ST_SKIP;
                end
                OC_SKIP: begin
                    if (cyc_start) begin
                        if (st_q.cnt == SKIP_LAST) st_d = ST_WIN;
                        else                       st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                OC_WINDOW: begin
                    if (cyc_start && (st_q.cnt == WIN_LAST)) begin
                        // window closes; a hit on this strobe is a new episode
                        st_d = ilim ? ST_SKIP : ST_IDLE;
                    end else if (ilim && !mask) begin
                        trip_d = 1'b1;
                        st_d   = ST_IDLE;
                    end else if (ilim && cyc_start) begin
                        // masked second hit at a period start: skip again
                        st_d = ST_SKIP;
                    end else if (cyc_start) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign skipping = (st_q.phase == OC_SKIP);
    assign oc_trip  = trip_d;

endmodule

// File: rtl/persist_filter.sv
module persist_filter #(
    parameter int LIMIT    = 2,
    parameter bit MASKABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cond,
    input  logic evt,
    input  logic mask,
    output logic trip
);

    localparam int             CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          mask_eff;

    generate
        if (MASKABLE) begin : g_mask
            assign mask_eff = mask;
        end else begin : g_nomask
            assign mask_eff = mask & 1'b0;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !cond)                 cnt_d = '0;
        else if (evt && (cnt_q != LIM))   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trip = cond && !clr && !mask_eff && (cnt_q == LIM);

endmodule

// File: rtl/discharge_latch.sv
module discharge_latch
    import buck_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trip_any,
    input  logic out_lo,
    input  logic out_hi,
    output logic fault,
    output logic lgate
);

    dis_state_t st_d, st_q;

    always_comb begin
        st_d.fault = enable && (st_q.fault || trip_any);
        if (!st_d.fault)                   st_d.lgate = 1'b0;
        else if (!st_q.fault)              st_d.lgate = 1'b1;
        else if (st_q.lgate && out_lo)     st_d.lgate = 1'b0;
        else if (!st_q.lgate && out_hi)    st_d.lgate = 1'b1;
        else                               st_d.lgate = st_q.lgate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault = st_q.fault;
    assign lgate = st_q.lgate;

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor #(
    parameter int SKIP_CYCLES = 8,
    parameter int WIN_CYCLES  = 8,
    parameter int UV_US       = 2,
    parameter int OV_CYCLES   = 16,
    parameter int FBS_US      = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_start,
    input  logic us_tick,
    input  logic ilim_det,
    input  logic fb_under,
    input  logic fb_over,
    input  logic hs_short,
    input  logic fb_short,
    input  logic ss_low,
    input  logic out_below_lo,
    input  logic out_above_hi,
    output logic ugate_inhibit,
    output logic fault_latched,
    output logic lgate_discharge
);

    logic clr;
    logic skipping, oc_trip, uv_trip, ov_trip, fs_trip, trip_any;
    logic fault, lgate;

    assign clr = !enable;

    oc_skip_guard #(
        .SKIP_CYCLES (SKIP_CYCLES),
        .WIN_CYCLES  (WIN_CYCLES)
    ) u_oc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cyc_start (cyc_start),
        .ilim      (ilim_det),
        .mask      (ss_low),
        .skipping  (skipping),
        .oc_trip   (oc_trip)
    );

    persist_filter #(.LIMIT(UV_US), .MASKABLE(1'b1)) u_uv (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .cond (fb_under), .evt (us_tick), .mask (ss_low), .trip (uv_trip)
    );

    persist_filter #(.LIMIT(OV_CYCLES), .MASKABLE(1'b0)) u_ov (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .cond (fb_over), .evt (cyc_start), .mask (ss_low), .trip (ov_trip)
    );

    persist_filter #(.LIMIT(FBS_US), .MASKABLE(1'b0)) u_fs (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .cond (fb_short), .evt (us_tick), .mask (ss_low), .trip (fs_trip)
    );

    assign trip_any = oc_trip | uv_trip | ov_trip | fs_trip | hs_short;

    discharge_latch u_dis (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .trip_any (trip_any),
        .out_lo   (out_below_lo),
        .out_hi   (out_above_hi),
        .fault    (fault),
        .lgate    (lgate)
    );

    assign ugate_inhibit   = skipping | fault;
    assign fault_latched   = fault;
    assign lgate_discharge = lgate;

endmodule

// File: rtl/buck_fault_checker.sv
module buck_fault_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cyc_start,
    input logic ilim_det,
    input logic out_above_hi,
    input logic ugate_inhibit,
    input logic fault_latched,
    input logic lgate_discharge
);

    AST_SKIP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cyc_start && ilim_det && !ugate_inhibit) |=> ugate_inhibit); // R1

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && enable) |=> fault_latched); // R9

    AST_INHIBIT_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> ugate_inhibit); // R9

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!fault_latched && !lgate_discharge)); // R10

    AST_DISCHARGE_ONLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        lgate_discharge |-> fault_latched); // R8

    AST_DISCHARGE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched) |-> lgate_discharge); // R8

    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && enable && !lgate_discharge && !out_above_hi) |=> !lgate_discharge); // R8

endmodule

bind buck_fault_supervisor buck_fault_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .cyc_start       (cyc_start),
    .ilim_det        (ilim_det),
    .out_above_hi    (out_above_hi),
    .ugate_inhibit   (ugate_inhibit),
    .fault_latched   (fault_latched),
    .lgate_discharge (lgate_discharge)
);

// File: tb/buck_fault_supervisor_test.sv
`timescale 1ns/1ps
module buck_fault_supervisor_test;

    localparam int SKIP_N = 8, WIN_N = 8, UV_N = 2, OV_N = 16, FS_N = 14;
    localparam int WD_LIMIT = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic cyc_start = 1'b0, us_tick = 1'b0;
    logic ilim_det = 1'b0, fb_under = 1'b0, fb_over = 1'b0;
    logic hs_short = 1'b0, fb_short = 1'b0, ss_low = 1'b0;
    logic out_below_lo = 1'b0, out_above_hi = 1'b0;
    logic ugate_inhibit, fault_latched, lgate_discharge;

    int    vectors = 0, misses = 0, wd = 0, phase = 0;
    bit    cmp_on = 1'b0, done = 1'b0;
    string cur_req = "R10";

    // reference model state
    int m_mode = 0, m_cnt = 0, m_uv = 0, m_ov = 0, m_fs = 0;
    bit m_flt = 0, m_lg = 0;

    always #2 clk = ~clk;

    buck_fault_supervisor uut (
        .clk (clk), .rst_n (rst_n), .enable (enable),
        .cyc_start (cyc_start), .us_tick (us_tick),
        .ilim_det (ilim_det), .fb_under (fb_under), .fb_over (fb_over),
        .hs_short (hs_short), .fb_short (fb_short), .ss_low (ss_low),
        .out_below_lo (out_below_lo), .out_above_hi (out_above_hi),
        .ugate_inhibit (ugate_inhibit), .fault_latched (fault_latched),
        .lgate_discharge (lgate_discharge)
    );

    // period strobe every 4 clocks, microsecond tick every 10 clocks
    always @(negedge clk) begin
        phase     <= phase + 1;
        cyc_start <= (phase % 4 == 3);
        us_tick   <= (phase % 10 == 9);
    end

    // behavioural reference, one step per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_uv = 0; m_ov = 0; m_fs = 0;
            m_flt = 0; m_lg = 0;
        end else begin
            bit trip, nflt;
            trip = 0;
            if (!enable) begin
                m_mode = 0; m_cnt = 0; m_uv = 0; m_ov = 0; m_fs = 0;
                m_flt = 0; m_lg = 0;
            end else begin
                if (fb_under && m_uv == UV_N && !ss_low) trip = 1;
                if (fb_over && m_ov == OV_N) trip = 1;
                if (fb_short && m_fs == FS_N) trip = 1;
                if (hs_short) trip = 1;
                if (m_mode == 0) begin
                    if (cyc_start && ilim_det) begin m_mode = 1; m_cnt = 0; end
                end else if (m_mode == 1) begin
                    if (cyc_start) begin
                        m_cnt++;
                        if (m_cnt == SKIP_N) begin m_mode = 2; m_cnt = 0; end
                    end
                end else begin
                    if (cyc_start && m_cnt == WIN_N - 1) begin
                        m_mode = ilim_det ? 1 : 0; m_cnt = 0;
                    end else if (ilim_det && !ss_low) begin
                        trip = 1; m_mode = 0; m_cnt = 0;
                    end else if (ilim_det && cyc_start) begin
                        m_mode = 1; m_cnt = 0;
                    end else if (cyc_start) m_cnt++;
                end
                m_uv = !fb_under ? 0 : (us_tick && m_uv < UV_N) ? m_uv + 1 : m_uv;
                m_ov = !fb_over  ? 0 : (cyc_start && m_ov < OV_N) ? m_ov + 1 : m_ov;
                m_fs = !fb_short ? 0 : (us_tick && m_fs < FS_N) ? m_fs + 1 : m_fs;
                nflt = m_flt || trip;
                if (!nflt)                     m_lg = 0;
                else if (!m_flt)               m_lg = 1;
                else if (m_lg && out_below_lo) m_lg = 0;
                else if (!m_lg && out_above_hi) m_lg = 1;
                m_flt = nflt;
            end
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "model ugate_inhibit", ugate_inhibit, m_flt || (m_mode == 1));
            chk(cur_req, "model fault_latched", fault_latched, m_flt);
            chk(cur_req, "model lgate_discharge", lgate_discharge, m_lg);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == WD_LIMIT && !done) begin
            misses++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_latch();
        enable = 1'b0; idle(2);
        chk("R9", "fault after enable low", fault_latched, 1'b0);
        enable = 1'b1; idle(2);
    endtask

    initial begin
        idle(5);
        chk("R10", "reset inhibit", ugate_inhibit, 1'b0);
        chk("R10", "reset fault", fault_latched, 1'b0);
        chk("R10", "reset lgate", lgate_discharge, 1'b0);
        rst_n = 1'b1; enable = 1'b1; cmp_on = 1'b1;
        idle(3);

        // R1 then R3: single hit, skip, quiet window, recovery
        cur_req = "R1";
        ilim_det = 1; idle(4); ilim_det = 0; idle(10);
        chk("R1", "skip inhibit", ugate_inhibit, 1'b1);
        cur_req = "R3"; idle(80);
        chk("R3", "inhibit after quiet window", ugate_inhibit, 1'b0);
        chk("R3", "no fault after quiet window", fault_latched, 1'b0);

        // R2: second hit inside window, then R8 discharge hysteresis
        cur_req = "R2";
        ilim_det = 1; idle(4); ilim_det = 0; idle(36);
        ilim_det = 1; idle(2); ilim_det = 0; idle(2);
        chk("R2", "fault after window hit", fault_latched, 1'b1);
        chk("R9", "inhibit while latched", ugate_inhibit, 1'b1);
        chk("R8", "discharge on entry", lgate_discharge, 1'b1);
        cur_req = "R8";
        out_below_lo = 1; idle(2); out_below_lo = 0;
        chk("R8", "lgate off below floor", lgate_discharge, 1'b0);
        idle(3);
        chk("R8", "lgate stays off", lgate_discharge, 1'b0);
        out_above_hi = 1; idle(2); out_above_hi = 0;
        chk("R8", "lgate on above ceiling", lgate_discharge, 1'b1);
        cur_req = "R9"; idle(20);
        chk("R9", "latch holds", fault_latched, 1'b1);
        clear_latch();

        // R6: over-current masked during soft-start
        cur_req = "R6"; ss_low = 1;
        ilim_det = 1; idle(4); ilim_det = 0; idle(36);
        ilim_det = 1; idle(2); ilim_det = 0; idle(2);
        chk("R6", "oc masked", fault_latched, 1'b0);
        ss_low = 0; idle(80);

        // R4: under-voltage persistence
        cur_req = "R4";
        fb_under = 1; idle(5); fb_under = 0; idle(3);
        chk("R4", "short uv ignored", fault_latched, 1'b0);
        fb_under = 1; idle(30);
        chk("R4", "uv fault", fault_latched, 1'b1);
        clear_latch();
        cur_req = "R6"; ss_low = 1; idle(40);
        chk("R6", "uv masked", fault_latched, 1'b0);
        ss_low = 0; idle(3);
        chk("R6", "uv latches after mask", fault_latched, 1'b1);
        fb_under = 0; clear_latch();

        // R5: over-voltage persistence, not masked
        cur_req = "R5";
        fb_over = 1; idle(40); fb_over = 0; idle(2);
        chk("R5", "short ov ignored", fault_latched, 1'b0);
        fb_over = 1; ss_low = 1; idle(80);
        chk("R5", "ov fault in soft-start", fault_latched, 1'b1);
        fb_over = 0; ss_low = 0; clear_latch();

        // R7: high-side short and feedback short
        cur_req = "R7";
        hs_short = 1; idle(1); hs_short = 0; idle(2);
        chk("R7", "hs short fault", fault_latched, 1'b1);
        clear_latch();
        fb_short = 1; ss_low = 1; idle(100);
        chk("R7", "fb short not yet", fault_latched, 1'b0);
        idle(60);
        chk("R7", "fb short fault", fault_latched, 1'b1);
        fb_short = 0; ss_low = 0; clear_latch();

        // R3: drifting periodic hits, window-close collisions, OV overlap
        cur_req = "R3";
        for (int i = 0; i < 24; i++) begin
            ilim_det = 1; idle(1 + (i % 3)); ilim_det = 0; idle(62 + i);
            if (fault_latched) clear_latch();
        end
        fb_over = 1;
        for (int i = 0; i < 6; i++) begin
            ilim_det = 1; idle(2); ilim_det = 0; idle(9 + i);
        end
        fb_over = 0; idle(4);
        chk("R5", "ov overlapped with skip", fault_latched, 1'b1);

        cur_req = "R10";
        enable = 0; idle(3);
        chk("R10", "disabled inhibit", ugate_inhibit, 1'b0);
        chk("R10", "disabled lgate", lgate_discharge, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule